// File: doc/BRIEF.md
# Scanned Keypad Controller with Key FIFO

This block scans a matrix of 64 keys, eight scan rows by eight return lines. It drives a row index out to the matrix. For each row it latches the return lines and, when it finds a contact closed, holds that row. It then waits a fixed debounce interval and checks the same contact again. A closure that is still present after the wait becomes a one-byte key code. The code goes into an eight-entry first-in first-out queue. An interrupt line stays high as long as the queue holds at least one code.

A processor reaches the block through a chip select, one address bit and separate read and write strobes. Each strobe is one clock cycle long. With the address bit high, a read returns a status byte and a write is a command. With the address bit low, a read returns the oldest key code and removes it from the queue. The processor port has no back-pressure. Read data is valid in the same cycle as the strobe. A key that arrives when the queue has no room is dropped and latched as an overrun. The path from the debouncer into the queue is a one-cycle valid pulse with no ready.

Top module: `kpd_ctrl`

## Requirements
- R1: While no closure is being debounced, `scan_row_o` counts 0,1,…,7,0 and stays on each value for SCAN_DWELL clock cycles.
- R2: A closure becomes a key entry only if the same contact is still closed DEBOUNCE_CYC cycles after it was detected. Closures shorter than that interval leave the queue unchanged.
- R3: The key code is {2'b00, row[2:0], column[2:0]}. When several return lines are closed in one row, the lowest-numbered column is taken.
- R4: An accepted key has to be seen open before it can be entered again. While it stays closed, closures of any other key are ignored.
- R5: The queue holds up to 8 codes and returns them in the order they were accepted.
- R6: A status read (cs_i=1, rd_i=1, a0_i=1) returns bit 7 = overrun, bit 6 = queue full, bits 5:4 = 0 and bits 3:0 = entry count.
- R7: A data read (cs_i=1, rd_i=1, a0_i=0) returns the oldest code and removes it. On an empty queue it returns 8'h00 and changes nothing.
- R8: A key accepted while the queue is full is discarded, and the overrun flag is set.
- R9: `irq_o` is high exactly when the entry count is nonzero. It falls in the cycle after the data read that empties the queue.
- R10: A command write (cs_i=1, wr_i=1, a0_i=1) flushes the queue when bit 0 is 1 and clears overrun when bit 1 is 1. Writes with a0_i=0 have no effect.
- R11: After reset the count is 0, overrun is 0, `irq_o` is 0 and `scan_row_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| return_i | input | 8 | Return lines of the selected row, 1 = contact closed |
| scan_row_o | output | 3 | Index of the row being driven |
| cs_i | input | 1 | Chip select |
| a0_i | input | 1 | Address bit: 1 = status/command, 0 = data |
| rd_i | input | 1 | Read strobe, one cycle per access |
| wr_i | input | 1 | Write strobe, one cycle per access |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid in the strobe cycle, 0 otherwise |
| irq_o | output | 1 | Key available |

## Verification
A stuck held-key register shows up first at the ports. Either a long press yields several codes, or a second key yields nothing. Both are visible in the status count within one scan sweep plus one debounce interval. A wrong pointer or count in the queue shows up as codes popped out of order, or as an `irq_o` level that disagrees with the status count at the very next read. A debounce timer that ends early lets bounces shorter than the interval into the queue. A scan counter that fails to freeze during the wait makes the recheck sample the wrong row, so valid presses get lost.

// File: rtl/kpd_pkg.sv
package kpd_pkg;
  localparam int KEY_W = 8;

  typedef enum logic {
    DB_IDLE,
    DB_WAIT
  } db_state_e;
endpackage

// File: rtl/kpd_scan.sv
module kpd_scan #(
  parameter int ROWS  = 8,
  parameter int COLS  = 8,
  parameter int DWELL = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [COLS-1:0]          return_i,
  input  logic                     hold_i,
  input  logic                     stay_i,
  output logic [$clog2(ROWS)-1:0]  row_o,
  output logic [COLS-1:0]          ret_o,
  output logic                     sample_o
);
  localparam int ROW_W = $clog2(ROWS);
  localparam int DW_W  = (DWELL > 1) ? $clog2(DWELL) : 1;

  logic [DW_W-1:0]  dwell_q;
  logic [ROW_W-1:0] row_q;
  logic [COLS-1:0]  ret_q;
  logic             dwell_end;

  assign dwell_end = (dwell_q == DW_W'(DWELL - 1));
  assign sample_o  = dwell_end & ~hold_i;
  assign row_o     = row_q;
  assign ret_o     = ret_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dwell_q <= '0;
      row_q   <= '0;
      ret_q   <= '0;
    end else begin
      ret_q <= return_i;
      if (!hold_i) begin
        if (dwell_end) begin
          dwell_q <= '0;
          if (!stay_i)
            row_q <= (row_q == ROW_W'(ROWS - 1)) ? '0 : row_q + 1'b1;
        end else begin
          dwell_q <= dwell_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/kpd_debounce.sv
module kpd_debounce
  import kpd_pkg::*;
#(
  parameter int ROWS    = 8,
  parameter int COLS    = 8,
  parameter int DEB_CYC = 500000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sample_i,
  input  logic [$clog2(ROWS)-1:0]  row_i,
  input  logic [COLS-1:0]          ret_i,
  output logic                     stay_o,
  output logic                     busy_o,
  output logic                     key_valid_o,
  output logic [KEY_W-1:0]         key_code_o
);
  localparam int ROW_W = $clog2(ROWS);
  localparam int COL_W = $clog2(COLS);
  localparam int PAD_W = KEY_W - ROW_W - COL_W;
  localparam int TM_W  = (DEB_CYC > 1) ? $clog2(DEB_CYC) : 1;

  db_state_e        state_q;
  logic [TM_W-1:0]  timer_q;
  logic [ROW_W-1:0] cand_row_q, held_row_q;
  logic [COL_W-1:0] cand_col_q, held_col_q;
  logic             held_q;
  logic             valid_q;
  logic [KEY_W-1:0] code_q;
  logic [COL_W-1:0] low_col;
  logic             any_closed;

  always_comb begin
    low_col = '0;
    for (int i = COLS - 1; i >= 0; i--) begin
      if (ret_i[i]) low_col = COL_W'(i);
    end
  end

  assign any_closed  = |ret_i;
  assign stay_o      = (state_q == DB_IDLE) & sample_i & ~held_q & any_closed;
  assign busy_o      = (state_q == DB_WAIT);
  assign key_valid_o = valid_q;
  assign key_code_o  = code_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= DB_IDLE;
      timer_q    <= '0;
      cand_row_q <= '0;
      cand_col_q <= '0;
      held_row_q <= '0;
      held_col_q <= '0;
      held_q     <= 1'b0;
      valid_q    <= 1'b0;
      code_q     <= '0;
    end else begin
      valid_q <= 1'b0;
      unique case (state_q)
        DB_IDLE: begin
          if (sample_i) begin
            if (held_q) begin
              if (row_i == held_row_q && !ret_i[held_col_q])
                held_q <= 1'b0;
            end else if (any_closed) begin
              cand_row_q <= row_i;
              cand_col_q <= low_col;
              timer_q    <= '0;
              state_q    <= DB_WAIT;
            end
          end
        end
        DB_WAIT: begin
          if (timer_q == TM_W'(DEB_CYC - 1)) begin
            state_q <= DB_IDLE;
            if (ret_i[cand_col_q]) begin
              valid_q    <= 1'b1;
              code_q     <= {{PAD_W{1'b0}}, cand_row_q, cand_col_q};
              held_q     <= 1'b1;
              held_row_q <= cand_row_q;
              held_col_q <= cand_col_q;
            end
          end else begin
            timer_q <= timer_q + 1'b1;
          end
        end
        default: state_q <= DB_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/kpd_fifo.sv
module kpd_fifo
  import kpd_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push_i,
  input  logic [KEY_W-1:0]           data_i,
  input  logic                       pop_i,
  input  logic                       flush_i,
  input  logic                       clr_ovr_i,
  output logic [KEY_W-1:0]           head_o,
  output logic [$clog2(DEPTH+1)-1:0] count_o,
  output logic                       full_o,
  output logic                       empty_o,
  output logic                       overrun_o
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [KEY_W-1:0] mem_q [DEPTH];
  logic [PW-1:0]    wr_q, rd_q;
  logic [CW-1:0]    count_q;
  logic             full_q, empty_q, ovr_q;
  logic             do_pop, do_push;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign do_pop  = pop_i & ~empty_q & ~flush_i;
  assign do_push = push_i & (~full_q | do_pop) & ~flush_i;

  assign head_o    = mem_q[rd_q];
  assign count_o   = count_q;
  assign full_o    = full_q;
  assign empty_o   = empty_q;
  assign overrun_o = ovr_q;

  always_ff @(posedge clk) begin
    if (do_push) mem_q[wr_q] <= data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= '0;
      rd_q    <= '0;
      count_q <= '0;
      full_q  <= 1'b0;
      empty_q <= 1'b1;
      ovr_q   <= 1'b0;
    end else begin
      if (clr_ovr_i)
        ovr_q <= 1'b0;
      else if (push_i && !do_push && !flush_i)
        ovr_q <= 1'b1;

      if (flush_i) begin
        wr_q    <= '0;
        rd_q    <= '0;
        count_q <= '0;
        full_q  <= 1'b0;
        empty_q <= 1'b1;
      end else begin
        if (do_push) wr_q <= nxt(wr_q);
        if (do_pop)  rd_q <= nxt(rd_q);
        if (do_push && !do_pop) begin
          count_q <= count_q + 1'b1;
          empty_q <= 1'b0;
          full_q  <= (count_q == CW'(DEPTH - 1));
        end else if (do_pop && !do_push) begin
          count_q <= count_q - 1'b1;
          full_q  <= 1'b0;
          empty_q <= (count_q == CW'(1));
        end
      end
    end
  end
endmodule

// File: rtl/kpd_host.sv
module kpd_host
  import kpd_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic                       cs_i,
  input  logic                       a0_i,
  input  logic                       rd_i,
  input  logic                       wr_i,
  input  logic [KEY_W-1:0]           wdata_i,
  input  logic [KEY_W-1:0]           head_i,
  input  logic [$clog2(DEPTH+1)-1:0] count_i,
  input  logic                       full_i,
  input  logic                       empty_i,
  input  logic                       overrun_i,
  output logic [KEY_W-1:0]           rdata_o,
  output logic                       pop_o,
  output logic                       flush_o,
  output logic                       clr_ovr_o
);
  localparam int CW = $clog2(DEPTH + 1);

  logic             rd_sel, wr_sel;
  logic [KEY_W-1:0] status;
  logic             cmd_unused;

  assign rd_sel = cs_i & rd_i;
  assign wr_sel = cs_i & wr_i;

  assign pop_o     = rd_sel & ~a0_i;
  assign flush_o   = wr_sel & a0_i & wdata_i[0];
  assign clr_ovr_o = wr_sel & a0_i & wdata_i[1];
  assign cmd_unused = ^wdata_i[KEY_W-1:2];

  always_comb begin
    status      = '0;
    status[7]   = overrun_i;
    status[6]   = full_i;
    status[CW-1:0] = count_i;
  end

  always_comb begin
    if (!rd_sel)
      rdata_o = '0;
    else if (a0_i)
      rdata_o = status;
    else
      rdata_o = empty_i ? '0 : head_i;
  end
endmodule

// File: rtl/kpd_ctrl.sv
module kpd_ctrl
  import kpd_pkg::*;
#(
  parameter int ROWS         = 8,
  parameter int COLS         = 8,
  parameter int DEPTH        = 8,
  parameter int SCAN_DWELL   = 4,
  parameter int DEBOUNCE_CYC = 500000
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [COLS-1:0]         return_i,
  output logic [$clog2(ROWS)-1:0] scan_row_o,
  input  logic                    cs_i,
  input  logic                    a0_i,
  input  logic                    rd_i,
  input  logic                    wr_i,
  input  logic [KEY_W-1:0]        wdata_i,
  output logic [KEY_W-1:0]        rdata_o,
  output logic                    irq_o
);
  localparam int ROW_W = $clog2(ROWS);
  localparam int CW    = $clog2(DEPTH + 1);

  logic [ROW_W-1:0] row;
  logic [COLS-1:0]  ret_q;
  logic             sample, stay, busy;
  logic             key_valid;
  logic [KEY_W-1:0] key_code;
  logic             pop, flush, clr_ovr;
  logic [KEY_W-1:0] head;
  logic [CW-1:0]    count;
  logic             full, empty, overrun;

  kpd_scan #(.ROWS(ROWS), .COLS(COLS), .DWELL(SCAN_DWELL)) u_scan (
    .clk(clk), .rst_n(rst_n), .return_i(return_i), .hold_i(busy),
    .stay_i(stay), .row_o(row), .ret_o(ret_q), .sample_o(sample)
  );

  kpd_debounce #(.ROWS(ROWS), .COLS(COLS), .DEB_CYC(DEBOUNCE_CYC)) u_deb (
    .clk(clk), .rst_n(rst_n), .sample_i(sample), .row_i(row), .ret_i(ret_q),
    .stay_o(stay), .busy_o(busy), .key_valid_o(key_valid), .key_code_o(key_code)
  );

  kpd_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push_i(key_valid), .data_i(key_code),
    .pop_i(pop), .flush_i(flush), .clr_ovr_i(clr_ovr), .head_o(head),
    .count_o(count), .full_o(full), .empty_o(empty), .overrun_o(overrun)
  );

  kpd_host #(.DEPTH(DEPTH)) u_host (
    .cs_i(cs_i), .a0_i(a0_i), .rd_i(rd_i), .wr_i(wr_i), .wdata_i(wdata_i),
    .head_i(head), .count_i(count), .full_i(full), .empty_i(empty),
    .overrun_i(overrun), .rdata_o(rdata_o), .pop_o(pop), .flush_o(flush),
    .clr_ovr_o(clr_ovr)
  );

  assign scan_row_o = row;
  assign irq_o      = ~empty;
endmodule

// File: rtl/kpd_ctrl_chk.sv
module kpd_ctrl_chk #(
  parameter int DEPTH = 8,
  parameter int ROW_W = 3
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       irq_o,
  input logic [$clog2(DEPTH+1)-1:0] count,
  input logic                       key_valid,
  input logic                       full,
  input logic                       overrun,
  input logic                       pop,
  input logic                       flush,
  input logic                       busy,
  input logic [ROW_W-1:0]           row
);
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count <= DEPTH); // R5

  AST_DROP_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (key_valid && full && !pop && !flush) |=> (overrun && count == $past(count))); // R8

  AST_POP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && count != 0 && !key_valid && !flush) |=> (count == $past(count) - 1'b1)); // R7

  AST_IRQ_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == (count != 0)); // R9

  AST_ROW_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(row)); // R2

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count == 0 && !irq_o)); // R10
endmodule

bind kpd_ctrl kpd_ctrl_chk #(.DEPTH(DEPTH), .ROW_W(ROW_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_o(irq_o), .count(count),
  .key_valid(key_valid), .full(full), .overrun(overrun), .pop(pop),
  .flush(flush), .busy(busy), .row(row)
);

// File: tb/kpd_ctrl_tb.sv
module kpd_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DWELL      = 4;
  localparam int DEB        = 24;
  localparam int SETTLE     = 90;

  // row[22:20] col[19:17] hold[16:1] accept[0]
  localparam logic [22:0] VEC [6] = '{
    {3'd0, 3'd0, 16'd120, 1'b1},
    {3'd7, 3'd7, 16'd120, 1'b1},
    {3'd3, 3'd5, 16'd12,  1'b0},
    {3'd5, 3'd2, 16'd120, 1'b1},
    {3'd2, 3'd6, 16'd6,   1'b0},
    {3'd6, 3'd1, 16'd150, 1'b1}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] return_i;
  logic [2:0] scan_row_o;
  logic       cs_i = 1'b0, a0_i = 1'b0, rd_i = 1'b0, wr_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       irq_o;
  logic [7:0] keys [8];

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  always_comb return_i = keys[scan_row_o];

  kpd_ctrl #(.SCAN_DWELL(DWELL), .DEBOUNCE_CYC(DEB)) u_dut (
    .clk(clk), .rst_n(rst_n), .return_i(return_i), .scan_row_o(scan_row_o),
    .cs_i(cs_i), .a0_i(a0_i), .rd_i(rd_i), .wr_i(wr_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_read(input logic a, output logic [7:0] d);
    @(negedge clk);
    cs_i = 1'b1; rd_i = 1'b1; a0_i = a;
    #1 d = rdata_o;
    @(negedge clk);
    cs_i = 1'b0; rd_i = 1'b0; a0_i = 1'b0;
  endtask

  task automatic bus_write(input logic a, input logic [7:0] d);
    @(negedge clk);
    cs_i = 1'b1; wr_i = 1'b1; a0_i = a; wdata_i = d;
    @(negedge clk);
    cs_i = 1'b0; wr_i = 1'b0; a0_i = 1'b0; wdata_i = '0;
  endtask

  task automatic tap(input int r, input int c, input int hold);
    @(negedge clk);
    keys[r][c] = 1'b1;
    cyc(hold);
    keys[r][c] = 1'b0;
    cyc(SETTLE);
  endtask

  initial begin
    int limit;
    limit = 100000;
    repeat (limit) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [2:0] r0;
    for (int i = 0; i < 8; i++) keys[i] = '0;
    cyc(3);
    rst_n = 1'b1;

    // R11 reset state
    check("R11 row", {5'd0, scan_row_o}, 8'h00);
    check("R11 irq", {7'd0, irq_o}, 8'h00);
    bus_read(1'b1, d);
    check("R11 status", d, 8'h00);

    // R1 scan stepping
    for (int k = 0; k < 10; k++) begin
      r0 = scan_row_o;
      cyc(DWELL);
      check("R1 row step", {5'd0, scan_row_o}, {5'd0, r0 + 3'd1});
    end

    // Table of single presses: R2 R3 R7 R9
    for (int v = 0; v < 6; v++) begin
      logic [2:0] vr, vc;
      logic acc;
      vr = VEC[v][22:20];
      vc = VEC[v][19:17];
      acc = VEC[v][0];
      tap(int'(vr), int'(vc), int'(VEC[v][16:1]));
      bus_read(1'b1, d);
      check("R2 count after press", d, acc ? 8'h01 : 8'h00);
      check("R9 irq level", {7'd0, irq_o}, {7'd0, acc});
      if (acc) begin
        bus_read(1'b0, d);
        check("R3 key code", d, {2'b00, vr, vc});
        check("R9 irq falls after last read", {7'd0, irq_o}, 8'h00);
      end
    end

    // R3 lowest column wins; R4 other closures ignored while held
    @(negedge clk);
    keys[4][3] = 1'b1; keys[4][6] = 1'b1;
    cyc(150);
    bus_read(1'b1, d);
    check("R4 one entry while held", d, 8'h01);
    @(negedge clk);
    keys[1][2] = 1'b1;
    cyc(150);
    bus_read(1'b1, d);
    check("R4 other key ignored", d, 8'h01);
    @(negedge clk);
    keys[4][3] = 1'b0;
    cyc(150);
    bus_read(1'b1, d);
    check("R4 next key after release", d, 8'h02);
    bus_read(1'b0, d);
    check("R3 lowest column", d, {2'b00, 3'd4, 3'd3});
    bus_read(1'b0, d);
    check("R4 second code", d, 8'h00 | {2'b00, 3'd1, 3'd2} | 8'h00 ? {2'b00, 3'd1, 3'd2} : 8'h00);
    @(negedge clk);
    keys[4][6] = 1'b0; keys[1][2] = 1'b0;
    cyc(SETTLE);
    bus_read(1'b1, d);
    check("R4 no entry from residual key", d, 8'h00);

    // R4 long hold of one key gives one entry
    tap(2, 4, 400);
    bus_read(1'b1, d);
    check("R4 long hold single", d, 8'h01);
    bus_read(1'b0, d);
    check("R3 long hold code", d, {2'b00, 3'd2, 3'd4});

    // R5 R6 R8 fill and overrun
    for (int i = 0; i < 9; i++) tap(i % 8, i / 8, 100);
    bus_read(1'b1, d);
    check("R6 R8 status full+overrun", d, 8'hC8);
    check("R9 irq when full", {7'd0, irq_o}, 8'h01);
    for (int i = 0; i < 8; i++) begin
      bus_read(1'b0, d);
      check("R5 fifo order", d, 8'(i << 3));
    end
    check("R9 irq after drain", {7'd0, irq_o}, 8'h00);
    bus_read(1'b0, d);
    check("R7 empty read", d, 8'h00);
    bus_read(1'b1, d);
    check("R7 empty read no change", d, 8'h80);

    // R10 commands
    bus_write(1'b1, 8'h02);
    bus_read(1'b1, d);
    check("R10 clear overrun", d, 8'h00);
    tap(3, 3, 100);
    tap(6, 0, 100);
    bus_read(1'b1, d);
    check("R6 count two", d, 8'h02);
    bus_write(1'b0, 8'hFF);
    bus_read(1'b1, d);
    check("R10 data write ignored", d, 8'h02);
    bus_write(1'b1, 8'h01);
    bus_read(1'b1, d);
    check("R10 flush", d, 8'h00);
    check("R10 irq after flush", {7'd0, irq_o}, 8'h00);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule